// File: doc/BRIEF.md
# Periodic Sensor Logging Scheduler

This block paces the storage and readout of a 32-bit sensor sample. A free-running cycle counter raises a logging strobe at a fixed interval. On every logging strobe the sample present at the input is written into a small on-chip word RAM, at the next slot of a wrapping address sequence. A second, independent counter with a longer interval raises a dump strobe. On a dump strobe the word most recently logged is read back and handed, one byte at a time, to an external serial transmitter.

The transmitter sits outside the block. A one-cycle request carries each byte. The block waits for the transmitter's done pulse before it offers the next byte, and a dump always consists of exactly four bytes, lowest byte first. When no dump is running, the request stays low, so the serial line stays at its idle level. A dump strobe that comes while a dump is still running is dropped. Both interval lengths are parameters counted in clock cycles.

Top module: `sensor_log_sched`

## Requirements
- R1: Counting the first cycle after reset release as cycle 0, `ram_we_o` is 1 in exactly the cycles c with c mod LOG_PERIOD = LOG_PERIOD-1, and 0 in all other cycles.
- R2: In each write cycle `ram_wdata_o` equals `sample_i` of that cycle, and `ram_addr_o` is the number of earlier writes since reset, modulo RAM_DEPTH (0, 1, ..., RAM_DEPTH-1, 0, ...).
- R3: A dump strobe occurs in the cycles c with c mod DUMP_PERIOD = DUMP_PERIOD-1. If no dump is running in that cycle, the first `tx_req_o` pulse comes in cycle c+2.
- R4: A dump sends exactly four bytes on `tx_byte_o`, each one marked by a one-cycle `tx_req_o` pulse. Byte n (n = 0..3) is bits [8n+7:8n] of the word most recently written to the RAM, so the lowest byte goes first.
- R5: When a logging strobe and a dump strobe fall in the same cycle, the dump sends the word written in that cycle.
- R6: After byte n of a dump (n < 3), the request for byte n+1 comes exactly two cycles after the cycle in which `tx_done_i` is 1 with `tx_busy_i` at 0. No request comes while the block waits for done.
- R7: A dump strobe that occurs while a dump is running has no effect: the running dump sends its four bytes unchanged, and no further request follows until the next accepted strobe.
- R8: `tx_req_o` is 0 in every cycle in which no dump is running.
- R9: While `rst_i` is 1, `ram_we_o` and `tx_req_o` are 0. After release, both interval counters, the RAM address sequence and the byte index start again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_i | input | DATA_W | Sensor sample to log |
| tx_busy_i | input | 1 | Transmitter is shifting a byte |
| tx_done_i | input | 1 | One-cycle pulse: transmitter finished its byte |
| ram_we_o | output | 1 | RAM write enable (logging strobe) |
| ram_addr_o | output | ADDR_W | RAM write address |
| ram_wdata_o | output | DATA_W | RAM write data |
| tx_req_o | output | 1 | One-cycle request to send `tx_byte_o` |
| tx_byte_o | output | 8 | Byte offered to the transmitter |

## Verification
The write controls are combinational from the logging counter, so they are checked in the strobe cycle itself, half a period after the edge that set the counter. The first byte request is checked two cycles after the dump strobe: one cycle for the RAM read and one for the registered read data. Each later request is expected exactly two cycles after the cycle in which the bench's transmitter model drives done. The bench keeps its own cycle count from reset release and computes every expected strobe cycle, address and byte from that count with modulo arithmetic. It checks at the falling edge, after its own inputs have settled, so each comparison falls in the cycle the requirement names. A slow transmitter setting makes a dump outlast the dump interval, so that a dropped strobe can be observed at the ports.

// File: rtl/slog_pkg.sv
package slog_pkg;

  typedef enum logic [2:0] {
    DS_IDLE,
    DS_READ,
    DS_SEND,
    DS_WAIT,
    DS_GAP
  } dump_state_e;

  // Pick byte idx out of a word, lowest byte at idx 0.
  function automatic logic [7:0] word_byte(input logic [63:0] word, input int unsigned idx);
    logic [63:0] shifted;
    shifted = word >> (8 * idx);
    return shifted[7:0];
  endfunction

  // Advance a wrapping pointer over a depth of entries.
  function automatic int unsigned wrap_next(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

  // True when a cycle count sits on the last cycle of an interval.
  function automatic logic at_period_end(input longint unsigned cnt, input longint unsigned period);
    return cnt == period - 1;
  endfunction

endpackage

// File: rtl/slog_period_timer.sv
module slog_period_timer #(
  parameter longint unsigned PERIOD = 60
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic stb_o
);
  import slog_pkg::*;

  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stb_o = at_period_end(longint'(cnt_q), PERIOD);

endmodule

// File: rtl/slog_word_ram.sv
module slog_word_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (re_i) begin
      rdata_o <= mem_q[raddr_i];
    end
  end

endmodule

// File: rtl/slog_dump_seq.sv
module slog_dump_seq #(
  parameter int DATA_W = 32,
  parameter int BYTES  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              dump_stb_i,
  input  logic              tx_busy_i,
  input  logic              tx_done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rd_en_o,
  output logic              tx_req_o,
  output logic [7:0]        tx_byte_o,
  output logic              active_o,
  output logic              waiting_o,
  output logic [IDX_W-1:0]  idx_o
);
  import slog_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  dump_state_e      state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= DS_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        DS_IDLE: begin
          if (dump_stb_i) begin
            state_q <= DS_READ;
            idx_q   <= '0;
          end
        end
        DS_READ: state_q <= DS_SEND;
        DS_SEND: state_q <= DS_WAIT;
        DS_WAIT: begin
          if (tx_done_i) begin
            if (idx_q == LAST_IDX) begin
              state_q <= DS_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= DS_GAP;
            end
          end
        end
        DS_GAP: begin
          if (!tx_busy_i) begin
            state_q <= DS_SEND;
          end
        end
        default: state_q <= DS_IDLE;
      endcase
    end
  end

  assign rd_en_o   = (state_q == DS_READ);
  assign tx_req_o  = (state_q == DS_SEND);
  assign tx_byte_o = word_byte(64'(rdata_i), int'(idx_q));
  assign active_o  = (state_q != DS_IDLE);
  assign waiting_o = (state_q == DS_WAIT);
  assign idx_o     = idx_q;

endmodule

// File: rtl/sensor_log_sched.sv
module sensor_log_sched #(
  parameter int              DATA_W      = 32,
  parameter int              RAM_DEPTH   = 4,
  parameter longint unsigned LOG_PERIOD  = 6000,
  parameter longint unsigned DUMP_PERIOD = 30000,
  parameter int              ADDR_W      = $clog2(RAM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              tx_busy_i,
  input  logic              tx_done_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              tx_req_o,
  output logic [7:0]        tx_byte_o
);
  import slog_pkg::*;

  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = (BYTES > 2) ? $clog2(BYTES) : 1;

  // Named internal events
  logic              log_stb;
  logic              dump_stb;
  logic              dump_active;
  logic              byte_wait;
  logic [IDX_W-1:0]  byte_idx;
  logic              rd_en;
  logic [DATA_W-1:0] rd_word;
  logic [ADDR_W-1:0] wr_ptr_q;
  logic [ADDR_W-1:0] last_addr_q;

  // Two interval counters, same structure, different periods
  for (genvar g = 0; g < 2; g++) begin : g_timer
    localparam longint unsigned P = (g == 0) ? LOG_PERIOD : DUMP_PERIOD;
    logic stb;
    slog_period_timer #(.PERIOD(P)) timer_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .stb_o (stb)
    );
  end
  assign log_stb  = g_timer[0].stb;
  assign dump_stb = g_timer[1].stb;

  // Write pointer and most recent slot
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wr_ptr_q    <= '0;
      last_addr_q <= '0;
    end else if (log_stb) begin
      wr_ptr_q    <= ADDR_W'(wrap_next(int'(wr_ptr_q), RAM_DEPTH));
      last_addr_q <= wr_ptr_q;
    end
  end

  assign ram_we_o    = log_stb;
  assign ram_addr_o  = wr_ptr_q;
  assign ram_wdata_o = sample_i;

  slog_word_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (RAM_DEPTH),
    .ADDR_W (ADDR_W)
  ) ram_i (
    .clk_i   (clk_i),
    .we_i    (log_stb),
    .waddr_i (wr_ptr_q),
    .wdata_i (sample_i),
    .re_i    (rd_en),
    .raddr_i (last_addr_q),
    .rdata_o (rd_word)
  );

  slog_dump_seq #(
    .DATA_W (DATA_W),
    .BYTES  (BYTES),
    .IDX_W  (IDX_W)
  ) seq_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .dump_stb_i (dump_stb),
    .tx_busy_i  (tx_busy_i),
    .tx_done_i  (tx_done_i),
    .rdata_i    (rd_word),
    .rd_en_o    (rd_en),
    .tx_req_o   (tx_req_o),
    .tx_byte_o  (tx_byte_o),
    .active_o   (dump_active),
    .waiting_o  (byte_wait),
    .idx_o      (byte_idx)
  );

endmodule

// File: rtl/sensor_log_sched_chk.sv
module sensor_log_sched_chk #(
  parameter int BYTES = 4,
  parameter int IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             ram_we_o,
  input logic             tx_req_o,
  input logic             tx_done_i,
  input logic             dump_stb,
  input logic             dump_active,
  input logic             byte_wait,
  input logic [IDX_W-1:0] byte_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  // R1
  we_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ram_we_o |=> !ram_we_o);

  // R3
  dump_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (dump_stb && !dump_active) |=> dump_active ##1 tx_req_o);

  // R4
  dump_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (byte_wait && tx_done_i && byte_idx == LAST_IDX) |=> !dump_active);

  // R6
  req_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_req_o |=> !tx_req_o);

  // R7
  stb_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (dump_stb && dump_active && !(byte_wait && tx_done_i)) |=> (dump_active && $stable(byte_idx)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !dump_active |-> !tx_req_o);

  // R9
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (!tx_req_o && !dump_active && byte_idx == '0));

endmodule

bind sensor_log_sched sensor_log_sched_chk #(
  .BYTES (BYTES),
  .IDX_W (IDX_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .ram_we_o    (ram_we_o),
  .tx_req_o    (tx_req_o),
  .tx_done_i   (tx_done_i),
  .dump_stb    (dump_stb),
  .dump_active (dump_active),
  .byte_wait   (byte_wait),
  .byte_idx    (byte_idx)
);

// File: tb/sensor_log_sched_tb_top.sv
`timescale 1ns/1ps
module sensor_log_sched_tb_top;

  localparam int LP    = 60;
  localparam int DP    = 300;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] sample = '0;
  logic        busy = 1'b0;
  logic        done = 1'b0;
  logic        ram_we;
  logic [1:0]  ram_addr;
  logic [31:0] ram_wdata;
  logic        tx_req;
  logic [7:0]  tx_byte;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sensor_log_sched #(
    .DATA_W      (32),
    .RAM_DEPTH   (DEPTH),
    .LOG_PERIOD  (LP),
    .DUMP_PERIOD (DP)
  ) dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .sample_i    (sample),
    .tx_busy_i   (busy),
    .tx_done_i   (done),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata),
    .tx_req_o    (tx_req),
    .tx_byte_o   (tx_byte)
  );

  // Bench reference state
  int          wcount;
  logic [31:0] last_word;
  bit          active;
  logic [31:0] dump_word;
  bit          dump_tie;
  int          nbytes;
  int          expect_req_at;
  int          countdown;
  int          ignored;
  int          dumps_done;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    wcount = 0; last_word = '0; active = 0; dump_word = '0; dump_tie = 0;
    nbytes = 0; expect_req_at = -1; countdown = 0; ignored = 0; dumps_done = 0;
    busy = 0; done = 0;
  endtask

  // One cycle, handled at the falling edge; c counts edges since release.
  task automatic do_cycle(input int c, input int lat, input int phase);
    bit exp_we;
    bit end_dump;
    end_dump = 0;
    // drive this cycle's inputs
    sample = (32'h9E3779B9 * 32'(c + 1000 * phase + 1)) ^ 32'(c);
    done = 0;
    if (countdown > 0) begin
      countdown--;
      if (countdown == 0) begin
        done = 1;
        busy = 0;
        if (nbytes == 4) end_dump = 1;
        else expect_req_at = c + 2;
      end
    end
    #1;
    // R1 / R2: logging strobe and write controls
    exp_we = ((c % LP) == LP - 1);
    check(ram_we == exp_we, "R1 write strobe", ram_we, exp_we);
    if (exp_we) begin
      check(ram_addr == 2'(wcount % DEPTH), "R2 write address", ram_addr, wcount % DEPTH);
      check(ram_wdata == sample, "R2 write data", ram_wdata, sample);
      last_word = sample;
      wcount++;
    end
    // R3 / R7: dump strobe
    if ((c % DP) == DP - 1) begin
      if (!active) begin
        active = 1;
        dump_word = last_word;
        dump_tie = exp_we;
        nbytes = 0;
        expect_req_at = c + 2;
      end else begin
        ignored++;
      end
    end
    // R4 / R5 / R6 / R8: byte requests
    if (tx_req) begin
      check(active && nbytes < 4, "R8 request only during a dump", tx_req, 0);
      check(c == expect_req_at, "R3/R6 request cycle", c, expect_req_at);
      if (nbytes < 4) begin
        if (dump_tie)
          check(tx_byte == dump_word[8*nbytes +: 8], "R5 tie word byte", tx_byte, dump_word[8*nbytes +: 8]);
        else
          check(tx_byte == dump_word[8*nbytes +: 8], "R4 byte order", tx_byte, dump_word[8*nbytes +: 8]);
      end
      nbytes++;
      expect_req_at = -1;
      busy = 1;
      countdown = lat;
    end else if (c == expect_req_at) begin
      check(0, "R3/R6 missing request", 0, 1);
      expect_req_at = -1;
    end
    if (end_dump) begin
      check(nbytes == 4, "R4 four bytes", nbytes, 4);
      active = 0;
      dumps_done++;
    end
  endtask

  task automatic run_phase(input int ncyc, input int lat, input int phase);
    for (int c = 0; c < ncyc; c++) begin
      do_cycle(c, lat, phase);
      @(negedge clk);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1;
    busy = 0;
    done = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(!ram_we && !tx_req, "R9 outputs low in reset", {ram_we, tx_req}, 0);
    end
    model_reset();
    rst = 0;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    apply_reset();
    // Fast transmitter: dumps at 299 and 599 coincide with writes (R5)
    run_phase(700, 5, 0);
    check(dumps_done == 2, "R4 dumps completed", dumps_done, 2);
    check(ignored == 0, "R7 no strobe dropped", ignored, 0);

    // Slow transmitter: a dump outlasts the interval
    apply_reset();
    run_phase(920, 80, 1);
    check(ignored == 1, "R7 strobe during dump dropped", ignored, 1);
    check(dumps_done == 1, "R7 single dump finished", dumps_done, 1);
    check(active, "R7 second dump running", active, 1);

    // Reset during a running dump, then restart (R9)
    apply_reset();
    run_phase(650, 3, 2);
    check(dumps_done == 2, "R9 dumps after restart", dumps_done, 2);
    check(wcount == 10, "R9 writes after restart", wcount, 10);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule